// File: doc/BRIEF.md
# Backlight Dimming PWM Generator

This block drives a panel backlight dimming pin with a pulse-width-modulated waveform. Software programs a 32-bit control word through a small register port: the upper half gives the length of one PWM cycle and the lower half gives how long the pin stays in its active state. Both are counted in time-base events, not raw clocks. A fixed prescaler produces one event every `PRESCALE` core clocks, so a 25 MHz clock divided by 16 with a period field of 5208 gives roughly 300 Hz.

There are two independent control words. A select input picks which one drives the pin. Every setting that shapes the waveform is captured into a working copy only at a cycle boundary, so a write made in the middle of a cycle never produces a short or stretched pulse. A configuration word sets the pin polarity, an inverted mapping for an optional 8-bit brightness input, and a minimum-brightness floor. When the brightness input is enabled, it replaces the programmed active time.

Top module: `bklt_pwm_top`

## Requirements
- R1: The control word holds the period in bits 31:16 and the active time in bits 15:0, both counted in events spaced `PRESCALE` (default 16) clocks apart. Over any whole number of PWM cycles, the pin is active for active×PRESCALE clocks out of every period×PRESCALE clocks, and each cycle begins with its active part.
- R2: An active time of zero keeps the pin inactive for the whole cycle.
- R3: An active time equal to or greater than the period keeps the pin active for the whole cycle, with no wrap and no gap.
- R4: A period of zero holds the pin at its inactive level.
- R5: Changes to the active time, the period, the control-word select or the brightness input are adopted only at the start of the next PWM cycle. The cycle in progress completes unchanged.
- R6: Reads are combinational on the address. Address 0 returns control word A, address 1 returns control word B, address 2 returns the configuration bits as written (bit 0, bit 1 and bits 15:8, with all other bits zero). Address 3 ignores writes and reads as zero. Reads return the last written value, not the working copy.
- R7: A select input of 0 uses control word A and a select input of 1 uses control word B.
- R8: Configuration bit 0 set makes the pin active-low. This takes effect on the next clock and does not wait for a cycle boundary.
- R9: When the brightness input is enabled, the active time becomes (period×level)>>8, with level 255 giving exactly the period. Configuration bit 1 set first maps the level to 255−level, so 0 gives maximum light.
- R10: The level used by R9, taken after the R9 inversion, is never below the floor held in configuration bits 15:8. The floor is expressed in normal-polarity terms.
- R11: After reset, all registers read zero and the pin is low, which is the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 ctrl A, 1 ctrl B, 2 config) |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for `addr` |
| pipe_sel | input | 1 | Chooses control word A (0) or B (1) |
| bright_en | input | 1 | Use the brightness level instead of the active-time field |
| bright_lvl | input | 8 | Brightness level 0..255 |
| pwm_o | output | 1 | Backlight dimming output |

## Verification
The assertions watch the working registers on every clock. They check that a zero active time never turns the pin on, that a saturated active time never lets it drop, and that a zero period keeps it dark. They also check that the working period and active time never move except at a boundary event, that prescaler ticks are never adjacent, and that a register write is held. The bench scenarios show the aggregate behaviour over whole cycles: active-clock counts for several ratios, the cycle in flight keeping its old width after a mid-cycle write, the switch between control words, pin inversion, and the brightness scaling with its inversion and floor. A cycle-level reference model then tracks the pin through randomized reconfigurations.

// File: rtl/bklt_pkg.sv
package bklt_pkg;

    localparam int FIELD_W    = 16;
    localparam int LEVEL_W    = 8;
    localparam int PRESCALE   = 16;
    localparam int ADDR_W     = 2;
    localparam int CTRL_W     = 2 * FIELD_W;
    localparam int FLOOR_LSB  = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL_A = 2'd0,
        REG_CTRL_B = 2'd1,
        REG_CONFIG = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [FIELD_W-1:0] period;
        logic [FIELD_W-1:0] active;
    } ctrl_word_t;

endpackage

// File: rtl/bklt_regs.sv
module bklt_regs
    import bklt_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int LW = LEVEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [2*FW-1:0] wr_data,
    output logic [2*FW-1:0] rd_data,
    output logic [2*FW-1:0] ctrl_a,
    output logic [2*FW-1:0] ctrl_b,
    output logic            pin_inv,
    output logic            lvl_inv,
    output logic [LW-1:0]   floor_lvl
);

    localparam int NUM_CTRL = 2;
    localparam int CW       = 2 * FW;

    typedef struct packed {
        logic [NUM_CTRL-1:0][CW-1:0] ctrl;
        logic                        pin_inv;
        logic                        lvl_inv;
        logic [LW-1:0]               floor_lvl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_CTRL; i++) begin
                if (addr == 2'(i)) st_d.ctrl[i] = wr_data;
            end
            if (addr == REG_CONFIG) begin
                st_d.pin_inv   = wr_data[0];
                st_d.lvl_inv   = wr_data[1];
                st_d.floor_lvl = wr_data[FLOOR_LSB +: LW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            REG_CTRL_A: rd_data = st_q.ctrl[0];
            REG_CTRL_B: rd_data = st_q.ctrl[1];
            REG_CONFIG: begin
                rd_data[0]               = st_q.pin_inv;
                rd_data[1]               = st_q.lvl_inv;
                rd_data[FLOOR_LSB +: LW] = st_q.floor_lvl;
            end
            default:    rd_data = '0;
        endcase
    end

    assign ctrl_a    = st_q.ctrl[0];
    assign ctrl_b    = st_q.ctrl[1];
    assign pin_inv   = st_q.pin_inv;
    assign lvl_inv   = st_q.lvl_inv;
    assign floor_lvl = st_q.floor_lvl;

    // R6: a write to a control word is held on the following cycle
    assert_wr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL_A) |=> (ctrl_a == $past(wr_data)));

    assert_wr_held_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL_B) |=> (ctrl_b == $past(wr_data)));

endmodule

// File: rtl/bklt_prescaler.sv
module bklt_prescaler #(
    parameter int DIV = bklt_pkg::PRESCALE
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } pre_t;

            pre_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (st_q.cnt == LAST) st_d.cnt = '0;
                else                  st_d.cnt = st_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign tick = (st_q.cnt == LAST);

            // R1: time-base events are never on adjacent clocks
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/bklt_duty_map.sv
module bklt_duty_map #(
    parameter int FW = bklt_pkg::FIELD_W,
    parameter int LW = bklt_pkg::LEVEL_W
) (
    input  logic [FW-1:0] period_i,
    input  logic [FW-1:0] raw_active_i,
    input  logic          bright_en_i,
    input  logic [LW-1:0] level_i,
    input  logic          lvl_inv_i,
    input  logic [LW-1:0] floor_i,
    output logic [FW-1:0] active_o
);

    localparam logic [LW-1:0] LVL_MAX = {LW{1'b1}};

    logic [LW-1:0] lvl_norm;
    logic [LW-1:0] lvl_eff;
    logic [FW-1:0] scaled;

    always_comb begin
        lvl_norm = lvl_inv_i ? (LVL_MAX - level_i) : level_i;
        lvl_eff  = (lvl_norm < floor_i) ? floor_i : lvl_norm;
        if (lvl_eff == LVL_MAX)
            scaled = period_i;
        else
            scaled = FW'(({{LW{1'b0}}, period_i} * {{FW{1'b0}}, lvl_eff}) >> LW);
        active_o = bright_en_i ? scaled : raw_active_i;
    end

endmodule

// File: rtl/bklt_wave.sv
module bklt_wave #(
    parameter int FW = bklt_pkg::FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [FW-1:0] src_period,
    input  logic [FW-1:0] src_active,
    output logic          on
);

    typedef struct packed {
        logic [FW-1:0] ev;
        logic [FW-1:0] period;
        logic [FW-1:0] active;
        logic          on;
    } wave_t;

    wave_t st_d, st_q;
    logic  at_end;
    logic  take;

    always_comb begin
        at_end = (st_q.period == '0) || (st_q.ev >= st_q.period - FW'(1));
        take   = tick && at_end;
        st_d   = st_q;
        if (tick) begin
            if (at_end) begin
                st_d.ev     = '0;
                st_d.period = src_period;
                st_d.active = src_active;
            end else begin
                st_d.ev = st_q.ev + FW'(1);
            end
        end
        st_d.on = (st_d.period != '0) &&
                  ((st_d.active >= st_d.period) || (st_d.ev < st_d.active));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on = st_q.on;

    // R2: a zero active time never lights the output
    assert_dark_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active == '0) |-> !st_q.on);

    // R3: saturated active time keeps the output on
    assert_solid_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.period != '0 && st_q.active >= st_q.period) |-> st_q.on);

    // R4: zero period keeps the output inactive
    assert_zero_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.period == '0) |-> !st_q.on);

    // R5: working settings only move at a boundary event
    assert_hold_settings_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(st_q.period) && $stable(st_q.active)));

endmodule

// File: rtl/bklt_pwm_top.sv
module bklt_pwm_top
    import bklt_pkg::*;
#(
    parameter int FW  = FIELD_W,
    parameter int LW  = LEVEL_W,
    parameter int DIV = PRESCALE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [2*FW-1:0] wr_data,
    output logic [2*FW-1:0] rd_data,
    input  logic            pipe_sel,
    input  logic            bright_en,
    input  logic [LW-1:0]   bright_lvl,
    output logic            pwm_o
);

    logic [2*FW-1:0] ctrl_a, ctrl_b, ctrl_sel;
    logic            pin_inv, lvl_inv;
    logic [LW-1:0]   floor_lvl;
    logic            tick;
    logic [FW-1:0]   eff_active;
    logic            wave_on;

    bklt_regs #(.FW(FW), .LW(LW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ctrl_a    (ctrl_a),
        .ctrl_b    (ctrl_b),
        .pin_inv   (pin_inv),
        .lvl_inv   (lvl_inv),
        .floor_lvl (floor_lvl)
    );

    bklt_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign ctrl_sel = pipe_sel ? ctrl_b : ctrl_a;

    bklt_duty_map #(.FW(FW), .LW(LW)) u_map (
        .period_i     (ctrl_sel[2*FW-1:FW]),
        .raw_active_i (ctrl_sel[FW-1:0]),
        .bright_en_i  (bright_en),
        .level_i      (bright_lvl),
        .lvl_inv_i    (lvl_inv),
        .floor_i      (floor_lvl),
        .active_o     (eff_active)
    );

    bklt_wave #(.FW(FW)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .src_period (ctrl_sel[2*FW-1:FW]),
        .src_active (eff_active),
        .on         (wave_on)
    );

    assign pwm_o = wave_on ^ pin_inv;

    // R8: the output always equals the wave state seen through the polarity bit
    assert_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_on) |-> (pwm_o == pin_inv));

endmodule

// File: tb/tb_bklt_pwm_top.sv
module tb_bklt_pwm_top;

    localparam int PRE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pipe_sel = 1'b0;
    logic        bright_en = 1'b0;
    logic [7:0]  bright_lvl = '0;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    bklt_pwm_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pipe_sel(pipe_sel),
        .bright_en(bright_en), .bright_lvl(bright_lvl), .pwm_o(pwm_o)
    );

    // Expected active time from the requirements (R9, R10)
    function automatic int exp_active(int per, int raw, bit en, int lvl, bit inv, int flr);
        int l;
        if (!en) return raw;
        l = inv ? 255 - lvl : lvl;
        if (l < flr) l = flr;
        if (l == 255) return per;
        return (per * l) >> 8;
    endfunction

    // Reference model tracking the register file and cycle position
    logic [31:0] m_a, m_b;
    bit          m_pinv, m_linv;
    int          m_floor, m_pre, m_ev, m_per, m_act;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a <= '0; m_b <= '0; m_pinv <= 0; m_linv <= 0; m_floor <= 0;
            m_pre <= 0; m_ev <= 0; m_per <= 0; m_act <= 0;
        end else begin
            logic [31:0] src;
            if (wr_en) begin
                case (addr)
                    2'd0: m_a <= wr_data;
                    2'd1: m_b <= wr_data;
                    2'd2: begin
                        m_pinv <= wr_data[0]; m_linv <= wr_data[1];
                        m_floor <= int'(wr_data[15:8]);
                    end
                    default: ;
                endcase
            end
            m_pre <= (m_pre == PRE - 1) ? 0 : m_pre + 1;
            if (m_pre == PRE - 1) begin
                if (m_per == 0 || m_ev + 1 >= m_per) begin
                    src   = pipe_sel ? m_b : m_a;
                    m_ev  <= 0;
                    m_per <= int'(src[31:16]);
                    m_act <= exp_active(int'(src[31:16]), int'(src[15:0]), bright_en,
                                        int'(bright_lvl), m_linv, m_floor);
                end else begin
                    m_ev <= m_ev + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit lit, exp;
            lit = (m_per != 0) && (m_act >= m_per || m_ev < m_act);
            exp = lit ^ m_pinv;
            checks++;
            if (pwm_o !== exp) begin
                errors++;
                $display("FAIL %s model pin: actual %0b expected %0b at %0t", cur_req, pwm_o, exp, $time);
            end
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_hi(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
    endtask

    task automatic wait_rise();
        logic prev;
        @(negedge clk);
        prev = pwm_o;
        forever begin
            @(negedge clk);
            if (pwm_o && !prev) break;
            prev = pwm_o;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        void'($urandom(32'd4242));
        // R11: reset state
        #1;
        chk("R11", int'(pwm_o), 0, "pin in reset");
        wait_clk(3);
        rst_n = 1'b1;
        rd_chk(2'd0, 32'h0, "R11");
        rd_chk(2'd1, 32'h0, "R11");
        rd_chk(2'd2, 32'h0, "R11");

        // R1: basic ratio, period 5 active 2
        cur_req = "R1";
        wr(2'd0, 32'h0005_0002);
        rd_chk(2'd0, 32'h0005_0002, "R6");
        wait_clk(200);
        count_hi(5 * PRE * 2, hi);
        chk("R1", hi, 2 * PRE * 2, "active clocks 2/5");

        // R5: mid-cycle write keeps the running cycle
        cur_req = "R5";
        wait_rise();
        hi = pwm_o ? 1 : 0;
        wr_en = 1'b1; addr = 2'd0; wr_data = 32'h0005_0004;
        @(negedge clk);
        wr_en = 1'b0;
        if (pwm_o) hi++;
        for (int i = 2; i < 5 * PRE; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        chk("R5", hi, 2 * PRE, "cycle in flight keeps old width");
        count_hi(5 * PRE, hi);
        chk("R5", hi, 4 * PRE, "next cycle adopts new width");
        rd_chk(2'd0, 32'h0005_0004, "R6");

        // R2: zero active time
        cur_req = "R2";
        wr(2'd0, 32'h0005_0000);
        wait_clk(200);
        count_hi(5 * PRE * 2, hi);
        chk("R2", hi, 0, "zero active time");

        // R3: equal and oversize active time
        cur_req = "R3";
        wr(2'd0, 32'h0005_0005);
        wait_clk(200);
        count_hi(5 * PRE * 2, hi);
        chk("R3", hi, 5 * PRE * 2, "active equals period");
        wr(2'd0, 32'h0005_0009);
        wait_clk(200);
        count_hi(5 * PRE * 2, hi);
        chk("R3", hi, 5 * PRE * 2, "active above period saturates");

        // R4: zero period
        cur_req = "R4";
        wr(2'd0, 32'h0000_0003);
        wait_clk(200);
        count_hi(200, hi);
        chk("R4", hi, 0, "zero period");

        // R7: select word B
        cur_req = "R7";
        wr(2'd0, 32'h0005_0002);
        wr(2'd1, 32'h0004_0001);
        pipe_sel = 1'b1;
        wait_clk(200);
        count_hi(4 * PRE * 2, hi);
        chk("R7", hi, 1 * PRE * 2, "word B drives pin");
        pipe_sel = 1'b0;
        wait_clk(200);
        count_hi(5 * PRE * 2, hi);
        chk("R7", hi, 2 * PRE * 2, "word A drives pin");

        // R8: active-low pin
        cur_req = "R8";
        wr(2'd2, 32'h0000_0001);
        wait_clk(20);
        count_hi(5 * PRE * 2, hi);
        chk("R8", hi, 3 * PRE * 2, "inverted pin");
        wr(2'd2, 32'h0000_0000);
        wait_clk(20);

        // R9: brightness scaling
        cur_req = "R9";
        wr(2'd0, 32'h0008_0001);
        bright_en = 1'b1; bright_lvl = 8'd128;
        wait_clk(300);
        count_hi(8 * PRE, hi);
        chk("R9", hi, 4 * PRE, "level 128 halves");
        bright_lvl = 8'd255;
        wait_clk(300);
        count_hi(8 * PRE, hi);
        chk("R9", hi, 8 * PRE, "level 255 full");
        wr(2'd2, 32'h0000_0002);
        bright_lvl = 8'd0;
        wait_clk(300);
        count_hi(8 * PRE, hi);
        chk("R9", hi, 8 * PRE, "inverted level 0 full");

        // R10: floor in normal terms
        cur_req = "R10";
        wr(2'd2, 32'h0000_C800);
        rd_chk(2'd2, 32'h0000_C800, "R6");
        bright_lvl = 8'd0;
        wait_clk(300);
        count_hi(8 * PRE, hi);
        chk("R10", hi, 6 * PRE, "floor 200 lifts level 0");
        bright_lvl = 8'd255;
        wait_clk(300);
        count_hi(8 * PRE, hi);
        chk("R10", hi, 8 * PRE, "level above floor");
        wr(2'd2, 32'h0000_0000);
        bright_en = 1'b0;

        // R6: unused address
        cur_req = "R6";
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'h0, "R6");
        rd_chk(2'd0, 32'h0008_0001, "R6");
        rd_chk(2'd2, 32'h0, "R6");
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk(2'd2, 32'h0000_FF03, "R6");

        // R5: randomized reconfiguration against the model
        cur_req = "R5";
        for (int k = 0; k < 100; k++) begin
            int sel;
            sel = $urandom_range(0, 3);
            if (sel == 0) wr(2'd0, {16'($urandom_range(0, 8)), 16'($urandom_range(0, 10))});
            else if (sel == 1) wr(2'd1, {16'($urandom_range(0, 8)), 16'($urandom_range(0, 10))});
            else if (sel == 2) wr(2'd2, {16'h0, 8'($urandom_range(0, 255)), 6'h0, 2'($urandom_range(0, 3))});
            else wr(2'($urandom_range(0, 3)), $urandom);
            @(negedge clk);
            pipe_sel   = 1'($urandom_range(0, 1));
            bright_en  = 1'($urandom_range(0, 1));
            bright_lvl = 8'($urandom_range(0, 255));
            wait_clk($urandom_range(20, 200));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule